// File: doc/BRIEF.md
# Control Register Translation Flush Controller

This block keeps the paging and mode control registers of an x86-style core: the machine control word (CR0), the page table base (CR3), the feature control word (CR4) and the state of the bit-20 address gate. Software-visible writes arrive one per cycle on a shared write port. The block stores each value after applying the fixed forcing rules, and it derives the hidden mode flags that the rest of the core reads without decoding the registers again.

Whenever a write changes state that the address translation cache depends on, the block raises a one-cycle flush strobe. A companion type bit says whether the flush must also drop global entries. The gate state is turned into a 32-bit mask that the core ANDs onto every physical address. Exception generation and the translation cache itself lie outside this block.

Top module: `crf_ctrl`

## Requirements
- R1: After synchronous reset, CR0 reads 0x60000010, CR3 and CR4 read 0, the gate mask reads 0xFFFFFFFF, the hidden flags are PE=0, ADDSEG=1, MP=EM=TS=0, OSFXSR=0, and no flush is signalled.
- R2: Write select encoding: 0 is CR0, 1 is CR3, 2 is CR4, 3 is the address gate (wr_data bit 0 is the new gate state). A CR0 write stores wr_data with bit 4 (ET) always forced to 1.
- R3: A CR0 write raises a full flush (flush_global=1) exactly when bit 31 (PG), bit 16 (WP) or bit 0 (PE) differs from the stored value; other bit changes cause no flush.
- R4: After a CR0 write, hidden PE equals CR0 bit 0, ADDSEG is 1 when PE is 0 and 0 when PE is 1, and MP, EM, TS equal CR0 bits 1, 2, 3.
- R5: A CR3 write always stores wr_data; it raises a non-global flush (flush_global=0) when stored CR0 bit 31 is 1 and no flush otherwise.
- R6: A CR4 write raises a full flush exactly when bit 7 (PGE), bit 5 (PAE) or bit 4 (PSE) changes.
- R7: When sse_present is 0, a CR4 write stores bit 9 (OSFXSR) as 0; the hidden OSFXSR flag always equals stored CR4 bit 9.
- R8: A gate write with a new state differing from the current one raises a full flush and sets the mask to 0xFFEFFFFF with bit 20 equal to the new state.
- R9: A gate write repeating the current state changes nothing and raises no flush.
- R10: flush_req is a single-cycle pulse in the cycle after the accepting clock edge, only in response to a write; flush_global is never high without flush_req.
- R11: With wr_en low, no register, flag or mask changes and no flush is signalled, whatever wr_sel and wr_data carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_sel | input | 2 | Target select: 0 CR0, 1 CR3, 2 CR4, 3 gate |
| wr_data | input | 32 | Write value |
| sse_present | input | 1 | Strap: streaming SIMD support present |
| cr0_q | output | 32 | Stored CR0 |
| cr3_q | output | 32 | Stored CR3 |
| cr4_q | output | 32 | Stored CR4 |
| gate_mask | output | 32 | Physical address mask from the gate state |
| hf_pe | output | 1 | Hidden protected-mode flag |
| hf_addseg | output | 1 | Hidden segment-base-add flag |
| hf_mp | output | 1 | Hidden monitor-coprocessor flag |
| hf_em | output | 1 | Hidden emulation flag |
| hf_ts | output | 1 | Hidden task-switched flag |
| hf_osfxsr | output | 1 | Hidden extended-state-save enable flag |
| flush_req | output | 1 | Translation flush strobe |
| flush_global | output | 1 | High when the flush must include global entries |

## Verification
On every cycle the assertions check the invariants that hold whatever the stimulus: ET set, the hidden flags in step with their register bits, ADDSEG set in real mode, the mask having only bit 20 free, OSFXSR clear after writes with the strap off, and flush strobes appearing only after writes with a non-global one tied to a CR3 write under paging. Which bit changes do and do not cause a flush, the flush type chosen per register, the repeated gate write, and the ignored writes with wr_en low can only be shown by the bench's scenarios, which compare against values worked out from the requirements.

// File: rtl/crf_pkg.sv
package crf_pkg;
  typedef enum logic [1:0] {
    SEL_CR0  = 2'd0,
    SEL_CR3  = 2'd1,
    SEL_CR4  = 2'd2,
    SEL_GATE = 2'd3
  } crf_sel_e;

  localparam int B_PE   = 0;
  localparam int B_MP   = 1;
  localparam int B_EM   = 2;
  localparam int B_TS   = 3;
  localparam int B_ET   = 4;
  localparam int B_WP   = 16;
  localparam int B_PG   = 31;

  localparam int B_PSE  = 4;
  localparam int B_PAE  = 5;
  localparam int B_PGE  = 7;
  localparam int B_OSFX = 9;

  localparam int B_GATE = 20;
endpackage

// File: rtl/crf_cr0_unit.sv
module crf_cr0_unit import crf_pkg::*; #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_VAL = 32'h6000_0010
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] din,
  output logic [W-1:0] cr0_q,
  output logic         pe,
  output logic         addseg,
  output logic         mp,
  output logic         em,
  output logic         ts,
  output logic         full_chg
);
  localparam logic [W-1:0] ET_BIT    = W'(1) << B_ET;
  localparam logic [W-1:0] MODE_MASK = (W'(1) << B_PG) | (W'(1) << B_WP) | (W'(1) << B_PE);

  logic [W-1:0] nv;

  always_comb begin
    nv       = din | ET_BIT;
    full_chg = we && (((nv ^ cr0_q) & MODE_MASK) != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr0_q  <= RST_VAL | ET_BIT;
      pe     <= RST_VAL[B_PE];
      addseg <= ~RST_VAL[B_PE];
      mp     <= RST_VAL[B_MP];
      em     <= RST_VAL[B_EM];
      ts     <= RST_VAL[B_TS];
    end else if (we) begin
      cr0_q  <= nv;
      pe     <= nv[B_PE];
      addseg <= ~nv[B_PE];
      mp     <= nv[B_MP];
      em     <= nv[B_EM];
      ts     <= nv[B_TS];
    end
  end

  // R2
  et_forced_chk: assert property (@(posedge clk) disable iff (rst) cr0_q[B_ET]);
  // R4
  pe_track_chk: assert property (@(posedge clk) disable iff (rst) pe == cr0_q[B_PE]);
  // R4
  addseg_real_chk: assert property (@(posedge clk) disable iff (rst) !pe |-> addseg);
  // R4
  fpu_flags_chk: assert property (@(posedge clk) disable iff (rst)
    {ts, em, mp} == cr0_q[B_TS:B_MP]);
endmodule

// File: rtl/crf_cr4_unit.sv
module crf_cr4_unit import crf_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         sse_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] cr4_q,
  output logic         osfxsr,
  output logic         full_chg
);
  localparam logic [W-1:0] OSFX_BIT  = W'(1) << B_OSFX;
  localparam logic [W-1:0] PAGE_MASK = (W'(1) << B_PGE) | (W'(1) << B_PAE) | (W'(1) << B_PSE);

  logic [W-1:0] nv;

  always_comb begin
    nv       = sse_en ? din : (din & ~OSFX_BIT);
    full_chg = we && (((nv ^ cr4_q) & PAGE_MASK) != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cr4_q  <= '0;
      osfxsr <= 1'b0;
    end else if (we) begin
      cr4_q  <= nv;
      osfxsr <= nv[B_OSFX];
    end
  end

  // R7
  osfx_mirror_chk: assert property (@(posedge clk) disable iff (rst) osfxsr == cr4_q[B_OSFX]);
  // R7
  osfx_strap_chk: assert property (@(posedge clk) disable iff (rst)
    (we && !sse_en) |=> !cr4_q[B_OSFX]);
endmodule

// File: rtl/crf_gate_unit.sv
module crf_gate_unit import crf_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic         din,
  output logic [W-1:0] mask_q,
  output logic         full_chg
);
  localparam logic [W-1:0] GATE_BIT = W'(1) << B_GATE;

  logic state_q;

  always_comb full_chg = we && (din != state_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= 1'b1;
      mask_q  <= '1;
    end else if (full_chg) begin
      state_q <= din;
      mask_q  <= din ? '1 : ~GATE_BIT;
    end
  end

  // R8
  mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q | GATE_BIT) == '1);
  // R9
  gate_same_chk: assert property (@(posedge clk) disable iff (rst)
    (we && din == state_q) |=> $stable(mask_q));
endmodule

// File: rtl/crf_ctrl.sv
module crf_ctrl import crf_pkg::*; #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         sse_present,
  output logic [W-1:0] cr0_q,
  output logic [W-1:0] cr3_q,
  output logic [W-1:0] cr4_q,
  output logic [W-1:0] gate_mask,
  output logic         hf_pe,
  output logic         hf_addseg,
  output logic         hf_mp,
  output logic         hf_em,
  output logic         hf_ts,
  output logic         hf_osfxsr,
  output logic         flush_req,
  output logic         flush_global
);
  logic we_cr0, we_cr3, we_cr4, we_gate;
  logic chg_cr0, chg_cr4, chg_gate;
  logic local_flush, full_flush;

  always_comb begin
    we_cr0      = wr_en && (wr_sel == SEL_CR0);
    we_cr3      = wr_en && (wr_sel == SEL_CR3);
    we_cr4      = wr_en && (wr_sel == SEL_CR4);
    we_gate     = wr_en && (wr_sel == SEL_GATE);
    full_flush  = chg_cr0 | chg_cr4 | chg_gate;
    local_flush = we_cr3 && cr0_q[B_PG];
  end

  crf_cr0_unit #(.W(W)) u_cr0 (
    .clk(clk), .rst(rst), .we(we_cr0), .din(wr_data),
    .cr0_q(cr0_q), .pe(hf_pe), .addseg(hf_addseg),
    .mp(hf_mp), .em(hf_em), .ts(hf_ts), .full_chg(chg_cr0)
  );

  crf_cr4_unit #(.W(W)) u_cr4 (
    .clk(clk), .rst(rst), .we(we_cr4), .sse_en(sse_present), .din(wr_data),
    .cr4_q(cr4_q), .osfxsr(hf_osfxsr), .full_chg(chg_cr4)
  );

  crf_gate_unit #(.W(W)) u_gate (
    .clk(clk), .rst(rst), .we(we_gate), .din(wr_data[0]),
    .mask_q(gate_mask), .full_chg(chg_gate)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cr3_q        <= '0;
      flush_req    <= 1'b0;
      flush_global <= 1'b0;
    end else begin
      if (we_cr3) cr3_q <= wr_data;
      flush_req    <= full_flush | local_flush;
      flush_global <= full_flush;
    end
  end

  // R10
  flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(wr_en));
  // R10
  global_implies_req_chk: assert property (@(posedge clk) disable iff (rst)
    flush_global |-> flush_req);
  // R5
  local_flush_src_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_req && !flush_global) |-> ($past(wr_sel) == SEL_CR3 && $past(cr0_q[B_PG])));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cr3_q) && !flush_req));
endmodule

// File: tb/crf_ctrl_test.sv
module crf_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  // {sel[1:0], data[31:0], expected readback[31:0], exp flush, exp global}
  localparam logic [67:0] VEC [NV] = '{
    {2'd1, 32'h0000_1000, 32'h0000_1000, 1'b0, 1'b0}, // R5 CR3, paging off
    {2'd0, 32'h0000_0001, 32'h0000_0011, 1'b1, 1'b1}, // R3 PE change
    {2'd0, 32'h0000_000F, 32'h0000_001F, 1'b0, 1'b0}, // R3 MP/EM/TS only
    {2'd0, 32'h8000_000F, 32'h8000_001F, 1'b1, 1'b1}, // R3 PG set
    {2'd1, 32'h0000_2000, 32'h0000_2000, 1'b1, 1'b0}, // R5 CR3, paging on
    {2'd2, 32'h0000_0200, 32'h0000_0200, 1'b0, 1'b0}, // R6 OSFXSR only
    {2'd2, 32'h0000_0220, 32'h0000_0220, 1'b1, 1'b1}, // R6 PAE
    {2'd2, 32'h0000_0230, 32'h0000_0230, 1'b1, 1'b1}, // R6 PSE
    {2'd3, 32'h0000_0000, 32'hFFEF_FFFF, 1'b1, 1'b1}, // R8 gate off
    {2'd3, 32'h0000_0000, 32'hFFEF_FFFF, 1'b0, 1'b0}, // R9 repeat
    {2'd3, 32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 1'b1}, // R8 gate on
    {2'd0, 32'h0001_000F, 32'h0001_001F, 1'b1, 1'b1}, // R3 PG off, WP on
    {2'd1, 32'h0000_3000, 32'h0000_3000, 1'b0, 1'b0}, // R5 paging off again
    {2'd0, 32'h0001_000E, 32'h0001_001E, 1'b1, 1'b1}  // R3 PE off
  };

  logic clk = 1'b0;
  logic rst;
  logic wr_en;
  logic [1:0] wr_sel;
  logic [31:0] wr_data;
  logic sse_present;
  logic [31:0] cr0_q, cr3_q, cr4_q, gate_mask;
  logic hf_pe, hf_addseg, hf_mp, hf_em, hf_ts, hf_osfxsr;
  logic flush_req, flush_global;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crf_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .sse_present(sse_present), .cr0_q(cr0_q), .cr3_q(cr3_q), .cr4_q(cr4_q),
    .gate_mask(gate_mask), .hf_pe(hf_pe), .hf_addseg(hf_addseg), .hf_mp(hf_mp),
    .hf_em(hf_em), .hf_ts(hf_ts), .hf_osfxsr(hf_osfxsr),
    .flush_req(flush_req), .flush_global(flush_global)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] readback(input logic [1:0] s);
    case (s)
      2'd0:    return cr0_q;
      2'd1:    return cr3_q;
      2'd2:    return cr4_q;
      default: return gate_mask;
    endcase
  endfunction

  // drive at negedge, capture at posedge, sample at the next negedge
  task automatic do_write(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0; sse_present = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 cr0", cr0_q, 32'h6000_0010);
    check("R1 cr3", cr3_q, 32'h0);
    check("R1 cr4", cr4_q, 32'h0);
    check("R1 mask", gate_mask, 32'hFFFF_FFFF);
    check("R1 flags", {26'd0, hf_pe, hf_addseg, hf_mp, hf_em, hf_ts, hf_osfxsr}, 32'h10);
    check("R1 flush", {30'd0, flush_req, flush_global}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][67:66], VEC[i][65:34]);
      check("R2/R5/R6/R8 readback", readback(VEC[i][67:66]), VEC[i][33:2]);
      check("R3/R5/R6/R8/R9 flush", {30'd0, flush_req, flush_global}, {30'd0, VEC[i][1:0]});
      @(negedge clk);
      check("R10 single pulse", {31'd0, flush_req}, 32'h0);
    end

    // R4 flags after PE off with MP/EM/TS set
    check("R4 real mode flags", {27'd0, hf_pe, hf_addseg, hf_mp, hf_em, hf_ts}, 32'h0F);
    do_write(2'd0, 32'h0000_0001);
    check("R4 protected flags", {27'd0, hf_pe, hf_addseg, hf_mp, hf_em, hf_ts}, 32'h10);
    check("R7 osfxsr mirror on", {31'd0, hf_osfxsr}, 32'h1);

    // R7 strap off clears OSFXSR, no paging bit change
    sse_present = 1'b0;
    do_write(2'd2, 32'h0000_0230);
    check("R7 cr4 strap off", cr4_q, 32'h0000_0030);
    check("R7 osfxsr flag", {31'd0, hf_osfxsr}, 32'h0);
    check("R6 no flush", {31'd0, flush_req}, 32'h0);
    sse_present = 1'b1;
    @(negedge clk);

    // R2 ET forced with all-zero write
    do_write(2'd0, 32'h0000_0000);
    check("R2 et forced", cr0_q, 32'h0000_0010);
    check("R3 pe clear flush", {30'd0, flush_req, flush_global}, 32'h3);
    @(negedge clk);

    // R11 wr_en low ignored for every select
    for (int s = 0; s < 4; s++) begin
      wr_sel = 2'(s); wr_data = 32'hFFFF_FFFE;
      @(posedge clk); @(negedge clk);
      check("R11 cr0 hold", cr0_q, 32'h0000_0010);
      check("R11 cr3 hold", cr3_q, 32'h0000_3000);
      check("R11 cr4 hold", cr4_q, 32'h0000_0030);
      check("R11 mask hold", gate_mask, 32'hFFFF_FFFF);
      check("R11 no flush", {31'd0, flush_req}, 32'h0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule